// File: doc/BRIEF.md
# SIMD Lane Insert, Extract and Duplicate Unit

This unit moves scalar data between a 32-bit general register and the lanes of a vector register. An insert writes a byte, halfword or word from the scalar into one lane of a 64-bit register value and keeps every other bit. An extract reads one lane of a 64-bit value into a 32-bit result, with zero or sign extension. A duplicate fills a 128-bit result, either with a scalar cut to 8, 16 or 32 bits or with one 32-bit element taken from a 64-bit source.

Lane size and lane number for insert and extract come from one 4-bit selector code. Its upper pair comes from the upper opcode field and its lower pair from the lower opcode field. Codes that fit no lane pattern raise an illegal flag. The result path is combinational and can be followed by an output register, chosen by a parameter.

Top module: `simd_lane_mover`

## Requirements
- R1: Operation codes are 0 insert, 1 extract, 2 scalar duplicate and 3 element duplicate. The selector is {sel_hi_i, sel_lo_i}. When selector AND 4'b1011 is zero, the lane is a 32-bit word and selector bit 2 picks the word: 0 gives bits [31:0] and 1 gives bits [63:32].
- R2: An insert returns the 64-bit vector operand in result bits [63:0] with only the addressed lane replaced by the low bits of the scalar. Result bits [127:64] are zero.
- R3: When selector bit 3 is 1, the lane is a byte with index selector[2:0]. Byte lane i occupies bits [8i+7:8i], so lane numbering is little-endian.
- R4: When selector bit 3 is 0 and bit 0 is 1, the lane is a halfword with index selector[2:1]. Halfword lane i occupies bits [16i+15:16i].
- R5: An extract of a word lane returns that word in result bits [31:0]. For every extract, result bits [127:32] are zero.
- R6: An extract of a byte or halfword lane sign-extends to 32 bits when unsigned_i is 0 and the lane MSB is 1. In every other case it zero-extends.
- R7: For insert and extract, selector codes 4'b0010 and 4'b0110 set illegal_o and give an all-zero result. Duplicates never set illegal_o.
- R8: A scalar duplicate uses 16-bit lanes if sel_lo_i[0] is 1. Otherwise it uses 8-bit lanes if sel_hi_i[1] is 1, and otherwise 32-bit lanes. It copies the scalar's low lane-width bits into every lane of the 128-bit result.
- R9: An element duplicate copies vec_i[31:0] (when word_sel_i is 0) or vec_i[63:32] (when word_sel_i is 1) into all four 32-bit lanes.
- R10: With REG_OUT=1 the outputs change one clock after the inputs. Holding rst_n low at a clock edge clears result_o and illegal_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Operation code |
| sel_hi_i | input | 2 | Upper pair of the selector |
| sel_lo_i | input | 2 | Lower pair of the selector |
| word_sel_i | input | 1 | Element pick for the element duplicate |
| unsigned_i | input | 1 | 1 selects zero extension on narrow extracts |
| scalar_i | input | 32 | General register value |
| vec_i | input | 64 | 64-bit vector operand |
| result_o | output | 128 | Operation result |
| illegal_o | output | 1 | Selector code fits no lane pattern |

## Verification
The assertions assume op_i, the selector bits and the data inputs are settled before each capturing edge. They also assume the registered configuration is in use, because the checks compare outputs with inputs from one cycle earlier. The bench meets both assumptions: it changes inputs only on the falling edge and holds them for a full cycle. It runs every operation code against all sixteen selector codes, both extension modes, both element picks and several data patterns. The data patterns include lanes whose MSB is set, so that sign fill and lane isolation are both exposed.

// File: rtl/simd_lane_pkg.sv
// Shared constants and types for the lane mover.
// Assumes a 32-bit scalar, a 64-bit lane register and a 128-bit wide result.
package simd_lane_pkg;
    localparam int SCL_W  = 32;
    localparam int DREG_W = 2 * SCL_W;
    localparam int QREG_W = 4 * SCL_W;
    localparam int SH_W   = $clog2(DREG_W);

    localparam logic [1:0] OP_INSERT    = 2'd0;
    localparam logic [1:0] OP_EXTRACT   = 2'd1;
    localparam logic [1:0] OP_DUP_SCAL  = 2'd2;
    localparam logic [1:0] OP_DUP_ELEM  = 2'd3;

    typedef enum logic [1:0] {
        LW_BYTE = 2'd0,
        LW_HALF = 2'd1,
        LW_WORD = 2'd2
    } lane_w_e;
endpackage

// File: rtl/lane_sel_decode.sv
// Turns the 4-bit selector code into a lane width, a lane index and an
// illegal indication. Assumes little-endian lane numbering.
module lane_sel_decode
    import simd_lane_pkg::*;
(
    input  logic [3:0] code_i,
    output lane_w_e    width_o,
    output logic [2:0] idx_o,
    output logic       bad_o
);
    // Classify the code; word test first, then byte, then halfword.
    always_comb begin
        width_o = LW_WORD;
        idx_o   = 3'd0;
        bad_o   = 1'b0;
        if ((code_i & 4'b1011) == 4'b0000) begin
            width_o = LW_WORD;
            idx_o   = {2'b00, code_i[2]};
        end else if (code_i[3]) begin
            width_o = LW_BYTE;
            idx_o   = code_i[2:0];
        end else if (code_i[0]) begin
            width_o = LW_HALF;
            idx_o   = {1'b0, code_i[2:1]};
        end else begin
            bad_o   = 1'b1;
        end
    end
endmodule

// File: rtl/lane_insert.sv
// Writes the low bits of the scalar into one lane of a 64-bit value and
// keeps every other bit. Assumes width/index come from lane_sel_decode.
module lane_insert
    import simd_lane_pkg::*;
(
    input  logic [DREG_W-1:0] vec_i,
    input  logic [SCL_W-1:0]  scalar_i,
    input  lane_w_e           width_i,
    input  logic [2:0]        idx_i,
    output logic [DREG_W-1:0] vec_o
);
    logic [SH_W-1:0]   shamt;
    logic [SCL_W-1:0]  wmask;
    logic [DREG_W-1:0] lane_mask;
    logic [DREG_W-1:0] lane_data;

    // Lane mask and bit offset from width and index.
    always_comb begin
        unique case (width_i)
            LW_BYTE: begin wmask = 32'h0000_00FF; shamt = {idx_i, 3'b000}; end
            LW_HALF: begin wmask = 32'h0000_FFFF; shamt = {idx_i[1:0], 4'b0000}; end
            default: begin wmask = 32'hFFFF_FFFF; shamt = {idx_i[0], 5'b00000}; end
        endcase
    end

    // Merge the shifted scalar into the cleared lane.
    always_comb begin
        lane_mask = {{SCL_W{1'b0}}, wmask} << shamt;
        lane_data = {{SCL_W{1'b0}}, scalar_i & wmask} << shamt;
        vec_o     = (vec_i & ~lane_mask) | lane_data;
    end
endmodule

// File: rtl/lane_extract.sv
// Reads one lane of a 64-bit value into 32 bits, with sign or zero fill
// for narrow lanes. Assumes width/index come from lane_sel_decode.
module lane_extract
    import simd_lane_pkg::*;
(
    input  logic [DREG_W-1:0] vec_i,
    input  lane_w_e           width_i,
    input  logic [2:0]        idx_i,
    input  logic              unsigned_i,
    output logic [SCL_W-1:0]  val_o
);
    logic [SH_W-1:0]   shamt;
    logic [DREG_W-1:0] shifted;
    logic              fill;

    // Align the addressed lane to bit 0 and extend it.
    always_comb begin
        unique case (width_i)
            LW_BYTE: shamt = {idx_i, 3'b000};
            LW_HALF: shamt = {idx_i[1:0], 4'b0000};
            default: shamt = {idx_i[0], 5'b00000};
        endcase
        shifted = vec_i >> shamt;
        fill    = 1'b0;
        unique case (width_i)
            LW_BYTE: begin
                fill  = ~unsigned_i & shifted[7];
                val_o = {{24{fill}}, shifted[7:0]};
            end
            LW_HALF: begin
                fill  = ~unsigned_i & shifted[15];
                val_o = {{16{fill}}, shifted[15:0]};
            end
            default: val_o = shifted[SCL_W-1:0];
        endcase
    end
endmodule

// File: rtl/lane_dup.sv
// Builds a 128-bit value with one scalar repeated in every lane, either
// from the scalar (8/16/32-bit lanes) or from a 32-bit element of vec_i.
module lane_dup
    import simd_lane_pkg::*;
(
    input  logic [SCL_W-1:0]  scalar_i,
    input  logic [DREG_W-1:0] vec_i,
    input  logic              from_elem_i,
    input  logic              word_sel_i,
    input  logic              size_half_i,
    input  logic              size_byte_i,
    output logic [QREG_W-1:0] dup_o
);
    localparam int NWORD = QREG_W / SCL_W;
    logic [SCL_W-1:0] pattern;

    // Form one 32-bit repeat unit by the size priority half, byte, word.
    always_comb begin
        if (from_elem_i)
            pattern = word_sel_i ? vec_i[DREG_W-1:SCL_W] : vec_i[SCL_W-1:0];
        else if (size_half_i)
            pattern = {2{scalar_i[15:0]}};
        else if (size_byte_i)
            pattern = {4{scalar_i[7:0]}};
        else
            pattern = scalar_i;
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign dup_o[w*SCL_W +: SCL_W] = pattern;
    end
endmodule

// File: rtl/simd_lane_mover.sv
// Top of the lane mover: decodes the selector, runs insert, extract and
// duplicate in parallel, picks by op_i and optionally registers the result.
// Assumes inputs are stable around the capturing edge when REG_OUT=1.
module simd_lane_mover
    import simd_lane_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [1:0]        sel_hi_i,
    input  logic [1:0]        sel_lo_i,
    input  logic              word_sel_i,
    input  logic              unsigned_i,
    input  logic [SCL_W-1:0]  scalar_i,
    input  logic [DREG_W-1:0] vec_i,
    output logic [QREG_W-1:0] result_o,
    output logic              illegal_o
);
    lane_w_e           lane_w;
    logic [2:0]        lane_idx;
    logic              code_bad;
    logic [DREG_W-1:0] ins_val;
    logic [SCL_W-1:0]  ext_val;
    logic [QREG_W-1:0] dup_val;
    logic [QREG_W-1:0] nxt_result;
    logic              nxt_illegal;

    lane_sel_decode u_dec (
        .code_i  ({sel_hi_i, sel_lo_i}),
        .width_o (lane_w),
        .idx_o   (lane_idx),
        .bad_o   (code_bad)
    );

    lane_insert u_ins (
        .vec_i    (vec_i),
        .scalar_i (scalar_i),
        .width_i  (lane_w),
        .idx_i    (lane_idx),
        .vec_o    (ins_val)
    );

    lane_extract u_ext (
        .vec_i      (vec_i),
        .width_i    (lane_w),
        .idx_i      (lane_idx),
        .unsigned_i (unsigned_i),
        .val_o      (ext_val)
    );

    lane_dup u_dup (
        .scalar_i    (scalar_i),
        .vec_i       (vec_i),
        .from_elem_i (op_i == OP_DUP_ELEM),
        .word_sel_i  (word_sel_i),
        .size_half_i (sel_lo_i[0]),
        .size_byte_i (sel_hi_i[1]),
        .dup_o       (dup_val)
    );

    // Select the operation result; a bad code zeroes insert/extract output.
    always_comb begin
        nxt_illegal = 1'b0;
        unique case (op_i)
            OP_INSERT: begin
                nxt_illegal = code_bad;
                nxt_result  = code_bad ? '0 : {{DREG_W{1'b0}}, ins_val};
            end
            OP_EXTRACT: begin
                nxt_illegal = code_bad;
                nxt_result  = code_bad ? '0 : {{(QREG_W-SCL_W){1'b0}}, ext_val};
            end
            default: nxt_result = dup_val;
        endcase
    end

    if (REG_OUT) begin : g_reg
        // Capture the result on each edge; clear under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_o  <= '0;
                illegal_o <= 1'b0;
            end else begin
                result_o  <= nxt_result;
                illegal_o <= nxt_illegal;
            end
        end

        p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            illegal_o |-> (result_o == '0));

        p_illegal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(op_i[1]) && ($past(sel_lo_i) == 2'b10)
             && !$past(sel_hi_i[1])) |-> illegal_o);

        p_ins_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_i) == OP_INSERT)) |-> (result_o[QREG_W-1:DREG_W] == '0));

        p_ext_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_i) == OP_EXTRACT)) |-> (result_o[QREG_W-1:SCL_W] == '0));

        p_dup_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_i) == OP_DUP_SCAL) && !$past(sel_lo_i[0])
             && $past(sel_hi_i[1]))
            |-> ((result_o[7:0] == $past(scalar_i[7:0]))
                 && (result_o[QREG_W-1:QREG_W-8] == $past(scalar_i[7:0]))));

        p_dup_elem_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_i) == OP_DUP_ELEM))
            |-> (!illegal_o && (result_o[31:0] == result_o[63:32])
                 && (result_o[31:0] == result_o[127:96])));
    end else begin : g_comb
        assign result_o  = nxt_result;
        assign illegal_o = nxt_illegal;
    end
endmodule

// File: tb/sim_simd_lane_mover.sv
`timescale 1ns/1ps
module sim_simd_lane_mover;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_i = '0;
    logic [1:0]   sel_hi_i = '0;
    logic [1:0]   sel_lo_i = '0;
    logic         word_sel_i = 1'b0;
    logic         unsigned_i = 1'b0;
    logic [31:0]  scalar_i = '0;
    logic [63:0]  vec_i = '0;
    logic [127:0] result_o;
    logic         illegal_o;
    int           n_checks = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    simd_lane_mover #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_hi_i(sel_hi_i),
        .sel_lo_i(sel_lo_i), .word_sel_i(word_sel_i), .unsigned_i(unsigned_i),
        .scalar_i(scalar_i), .vec_i(vec_i), .result_o(result_o), .illegal_o(illegal_o)
    );

    // Expected {illegal, result} from the written requirements.
    function automatic logic [128:0] model(int op, int code, int uns, int ws,
                                           logic [31:0] s, logic [63:0] v);
        logic [127:0] r = '0;
        int lw, li;
        if (op < 2) begin
            if (code == 2 || code == 6) return {1'b1, 128'b0};
            if ((code & 11) == 0) begin lw = 32; li = (code >> 2) & 1; end
            else if ((code & 8) != 0) begin lw = 8; li = code & 7; end
            else begin lw = 16; li = (code >> 1) & 3; end
            if (op == 0) begin
                r[63:0] = v;
                for (int b = 0; b < lw; b++) r[li*lw + b] = s[b];
            end else begin
                for (int b = 0; b < lw; b++) r[b] = v[li*lw + b];
                if (lw < 32 && uns == 0 && r[lw-1] == 1'b1)
                    for (int b = lw; b < 32; b++) r[b] = 1'b1;
            end
        end else if (op == 2) begin
            lw = ((code & 1) != 0) ? 16 : (((code & 8) != 0) ? 8 : 32);
            for (int k = 0; k < 128; k++) r[k] = s[k % lw];
        end else begin
            for (int k = 0; k < 128; k++) r[k] = v[ws*32 + (k % 32)];
        end
        return {1'b0, r};
    endfunction

    task automatic check(string tag, logic [128:0] exp);
        n_checks++;
        if ({illegal_o, result_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: got ill=%b res=%h, expected ill=%b res=%h",
                     tag, illegal_o, result_o, exp[128], exp[127:0]);
        end
    endtask

    initial begin
        logic [31:0] scl [4];
        logic [63:0] vcs [4];
        string tag;
        scl[0] = 32'hDEAD_BEEF; scl[1] = 32'h0000_007F;
        scl[2] = 32'h1234_8001; scl[3] = 32'hFFFF_FFFF;
        vcs[0] = 64'h0123_4567_89AB_CDEF; vcs[1] = 64'hFEDC_BA98_7654_3210;
        vcs[2] = 64'h8080_8080_7F7F_7F7F; vcs[3] = 64'h0000_0000_0000_0000;

        // R10: reset clears the outputs even with busy inputs.
        op_i = 2'd3; vec_i = vcs[0]; scalar_i = scl[0];
        repeat (3) @(negedge clk);
        check("R10 reset", {1'b0, 128'b0});
        rst_n = 1'b1;

        for (int op = 0; op < 4; op++)
            for (int code = 0; code < 16; code++)
                for (int uns = 0; uns < 2; uns++)
                    for (int ws = 0; ws < 2; ws++)
                        for (int p = 0; p < 4; p++) begin
                            op_i = op[1:0]; sel_hi_i = code[3:2]; sel_lo_i = code[1:0];
                            unsigned_i = uns[0]; word_sel_i = ws[0];
                            scalar_i = scl[p]; vec_i = vcs[(p + code) % 4];
                            @(negedge clk);
                            if (op < 2 && (code == 2 || code == 6)) tag = "R7";
                            else if (op == 0 && (code & 11) == 0) tag = "R1";
                            else if (op == 0 && (code & 8) != 0) tag = "R2 R3";
                            else if (op == 0) tag = "R4";
                            else if (op == 1 && (code & 11) == 0) tag = "R5";
                            else if (op == 1) tag = "R6";
                            else if (op == 2) tag = "R8";
                            else tag = "R9";
                            check(tag, model(op, code, uns, ws, scalar_i, vec_i));
                        end

        // R10: one-cycle latency; output still holds the old value before the edge.
        op_i = 2'd2; sel_hi_i = 2'b00; sel_lo_i = 2'b00; scalar_i = 32'hA5A5_0001;
        @(negedge clk);
        op_i = 2'd1; sel_hi_i = 2'b10; sel_lo_i = 2'b00; vec_i = 64'h0000_0000_0000_0080;
        unsigned_i = 1'b0;
        #1;
        check("R10 hold", {1'b0, {4{32'hA5A5_0001}}});
        @(negedge clk);
        check("R10 R6 latency", {1'b0, 96'b0, 32'hFFFF_FF80});

        // R10: reset mid-run clears the outputs again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reclear", {1'b0, 128'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule